// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data-memory addresses for a signal-processing datapath that walks delay lines, filter taps and transform buffers. It keeps two banks of buffer descriptors, one primary and one secondary. Each bank holds a number of descriptors, and each descriptor has four fields: a current pointer, a signed step, a window size and a window start. On every access request the block returns the selected descriptor's pointer as the address. It then advances the pointer by the step and folds it back into the window when it leaves either end. Software never has to test for the end of a buffer.

A window may start at any address; no alignment is required. A window size of zero turns folding off, and the pointer then moves linearly, modulo the address width. For transform data ordering the output address can instead be shown with its low N bits mirrored, while the stored pointer keeps advancing by the normal rule. A bank-select input picks the primary or secondary bank for each access. A single write port loads one field of one descriptor per cycle.

Top module: `circ_dag`

## Requirements
- R1: While reset is asserted and after it is released, `addr_vld` is 0 and `addr` is 0. Every field of every descriptor in both banks starts at 0.
- R2: When `acc_en` is high at a rising edge, `addr_vld` is 1 after that edge and `addr` holds the selected descriptor's pointer as it stood before the access. This is the pointer value, or its mirrored form under R7.
- R3: With a window size of 0, an access moves the pointer to pointer + step, with the step read as two's complement and the result taken modulo 2^AW.
- R4: With a non-zero window size and a non-negative step, if pointer + step is at or above start + size, the new pointer is pointer + step − size. The comparison is done without truncation, so a window that ends exactly at 2^AW is handled.
- R5: With a non-zero window size and a negative step, if pointer + step is below the window start, the new pointer is pointer + step + size.
- R6: The window start may be any address, including values that are not multiples of the size.
- R7: With `brev_en` high, `addr` equals the pointer with bits [N−1:0] reversed in order and the upper bits unchanged, where N is `brev_bits` clamped to AW. N = 0 leaves the pointer unchanged. The stored pointer still advances by R3 to R5.
- R8: `bank_sel` (0 = primary, 1 = secondary) chooses the bank used by the access in that same cycle. Descriptors in the bank that is not selected keep their contents.
- R9: When a write and an access address the same bank and descriptor in the same cycle, the access uses the newly written field value. If the write targets the pointer, the stored result is the written value advanced by the step.
- R10: A write with `wr_en` high loads `wr_data` into one field of descriptor `wr_buf` in bank `wr_bank` and into nothing else. The field codes are 0 = pointer, 1 = step, 2 = window size, 3 = window start.
- R11: In a cycle without `acc_en`, `addr_vld` is 0 after the edge and `addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel | input | 1 | Bank used by the access: 0 primary, 1 secondary |
| acc_en | input | 1 | Access request |
| acc_buf | input | BUFW | Descriptor number for the access |
| brev_en | input | 1 | Show the address in mirrored-bit form |
| brev_bits | input | BW | Number of low bits to mirror |
| wr_en | input | 1 | Descriptor field write |
| wr_bank | input | 1 | Bank of the written descriptor |
| wr_buf | input | BUFW | Descriptor number of the write |
| wr_field | input | 2 | Field code: 0 pointer, 1 step, 2 size, 3 start |
| wr_data | input | AW | Value written |
| addr_vld | output | 1 | An address was issued at the last edge |
| addr | output | AW | Issued address |

## Verification
The address and its valid flag are registered. Both are due on the first rising edge after the edge that samples `acc_en`. The bench drives every input on a falling edge and reads the outputs on the next falling edge, half a period after the edge that updates them. A pointer update is visible only through the next access, so each wrap case is checked as a run of back-to-back accesses, each compared one cycle after it is issued. Writes and same-cycle accesses are driven together in one falling-edge slot, so that the write-first rule is seen in that very access's result.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [1:0] {
    FLD_PTR   = 2'd0,
    FLD_STEP  = 2'd1,
    FLD_SIZE  = 2'd2,
    FLD_START = 2'd3
  } dag_field_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/dag_rst_sync.sv
module dag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/dag_regfile.sv
module dag_regfile
  import dag_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NBUF = 8,
  parameter int unsigned BUFW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [BUFW-1:0] wr_buf,
  input  dag_field_e      wr_field,
  input  logic [AW-1:0]   wr_data,
  input  logic            rd_bank,
  input  logic [BUFW-1:0] rd_buf,
  output logic [AW-1:0]   rd_ptr,
  output logic [AW-1:0]   rd_step,
  output logic [AW-1:0]   rd_size,
  output logic [AW-1:0]   rd_start,
  input  logic            upd_en,
  input  logic [AW-1:0]   upd_ptr
);

  localparam int unsigned NENT = NUM_BANKS * NBUF;
  localparam int unsigned EW   = $clog2(NENT);

  logic [EW-1:0] wr_ent;
  logic [EW-1:0] rd_ent;
  logic [AW-1:0] ptr_all   [NENT];
  logic [AW-1:0] step_all  [NENT];
  logic [AW-1:0] size_all  [NENT];
  logic [AW-1:0] start_all [NENT];

  assign wr_ent = EW'(wr_bank) * EW'(NBUF) + EW'(wr_buf);
  assign rd_ent = EW'(rd_bank) * EW'(NBUF) + EW'(rd_buf);

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic          wr_hit;
    logic          upd_hit;
    logic          ptr_ce, step_ce, size_ce, start_ce;
    logic [AW-1:0] ptr_d;
    logic [AW-1:0] ptr_q, step_q, size_q, start_q;

    always_comb begin
      wr_hit   = wr_en  && (wr_ent == EW'(e));
      upd_hit  = upd_en && (rd_ent == EW'(e));
      ptr_ce   = upd_hit || (wr_hit && (wr_field == FLD_PTR));
      step_ce  = wr_hit && (wr_field == FLD_STEP);
      size_ce  = wr_hit && (wr_field == FLD_SIZE);
      start_ce = wr_hit && (wr_field == FLD_START);
      ptr_d    = upd_hit ? upd_ptr : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (ptr_ce) begin
        ptr_q <= ptr_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        step_q <= '0;
      end else if (step_ce) begin
        step_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q <= '0;
      end else if (size_ce) begin
        size_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
      end else if (start_ce) begin
        start_q <= wr_data;
      end
    end

    assign ptr_all[e]   = ptr_q;
    assign step_all[e]  = step_q;
    assign size_all[e]  = size_q;
    assign start_all[e] = start_q;
  end

  // Read with write-first bypass for a same-cycle write to the same entry.
  always_comb begin
    rd_ptr   = ptr_all[rd_ent];
    rd_step  = step_all[rd_ent];
    rd_size  = size_all[rd_ent];
    rd_start = start_all[rd_ent];
    if (wr_en && (wr_ent == rd_ent)) begin
      case (wr_field)
        FLD_PTR:   rd_ptr   = wr_data;
        FLD_STEP:  rd_step  = wr_data;
        FLD_SIZE:  rd_size  = wr_data;
        FLD_START: rd_start = wr_data;
        default:   rd_ptr   = ptr_all[rd_ent];
      endcase
    end
  end

endmodule

// File: rtl/dag_postmod.sv
module dag_postmod #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] start,
  output logic [AW-1:0] nxt
);

  localparam int unsigned XW = AW + 2;

  logic signed [XW-1:0] sum_s;
  logic signed [XW-1:0] start_s;
  logic signed [XW-1:0] size_s;
  logic signed [XW-1:0] end_s;
  logic signed [XW-1:0] fix_s;

  always_comb begin
    start_s = $signed({2'b00, start});
    size_s  = $signed({2'b00, size});
    end_s   = start_s + size_s;
    sum_s   = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
    fix_s   = sum_s;
    if (size != '0) begin
      if (!step[AW-1] && (sum_s >= end_s)) begin
        fix_s = sum_s - size_s;
      end else if (step[AW-1] && (sum_s < start_s)) begin
        fix_s = sum_s + size_s;
      end
    end
    nxt = fix_s[AW-1:0];
  end

endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] ptr,
  input  logic          en,
  input  logic [BW-1:0] nbits,
  output logic [AW-1:0] out
);

  int n;

  always_comb begin
    n   = (int'(nbits) > int'(AW)) ? int'(AW) : int'(nbits);
    out = ptr;
    if (en) begin
      for (int i = 0; i < int'(AW); i++) begin
        if (i < n) begin
          out[i] = ptr[n - 1 - i];
        end
      end
    end
  end

endmodule

// File: rtl/circ_dag.sv
module circ_dag
  import dag_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NBUF = 8,
  localparam int unsigned BUFW = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int unsigned BW   = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bank_sel,
  input  logic            acc_en,
  input  logic [BUFW-1:0] acc_buf,
  input  logic            brev_en,
  input  logic [BW-1:0]   brev_bits,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [BUFW-1:0] wr_buf,
  input  logic [1:0]      wr_field,
  input  logic [AW-1:0]   wr_data,
  output logic            addr_vld,
  output logic [AW-1:0]   addr
);

  logic          rst_sync_n;
  logic [AW-1:0] rd_ptr, rd_step, rd_size, rd_start;
  logic [AW-1:0] nxt_ptr;
  logic [AW-1:0] shown_addr;
  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_ce;

  dag_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dag_regfile #(.AW(AW), .NBUF(NBUF), .BUFW(BUFW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_buf   (wr_buf),
    .wr_field (dag_field_e'(wr_field)),
    .wr_data  (wr_data),
    .rd_bank  (bank_sel),
    .rd_buf   (acc_buf),
    .rd_ptr   (rd_ptr),
    .rd_step  (rd_step),
    .rd_size  (rd_size),
    .rd_start (rd_start),
    .upd_en   (acc_en),
    .upd_ptr  (nxt_ptr)
  );

  dag_postmod #(.AW(AW)) u_pm (
    .ptr   (rd_ptr),
    .step  (rd_step),
    .size  (rd_size),
    .start (rd_start),
    .nxt   (nxt_ptr)
  );

  dag_bitrev #(.AW(AW), .BW(BW)) u_br (
    .ptr   (rd_ptr),
    .en    (brev_en),
    .nbits (brev_bits),
    .out   (shown_addr)
  );

  always_comb begin
    vld_d   = acc_en;
    addr_ce = acc_en;
    addr_d  = shown_addr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else if (addr_ce) begin
      addr_q <= addr_d;
    end
  end

  assign addr_vld = vld_q;
  assign addr     = addr_q;

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          brev_en,
  input logic [BW-1:0] brev_bits,
  input logic          addr_vld,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] rd_step,
  input logic [AW-1:0] rd_size,
  input logic [AW-1:0] rd_start,
  input logic [AW-1:0] nxt_ptr
);

  localparam logic [AW+1:0] SPAN = {2'b01, {AW{1'b0}}};

  logic [AW+1:0] start_x, end_x, ptr_x, nxt_x, mag_x, size_x;
  logic          ok_win, nxt_in;

  always_comb begin
    start_x = {2'b00, rd_start};
    size_x  = {2'b00, rd_size};
    end_x   = start_x + size_x;
    ptr_x   = {2'b00, rd_ptr};
    nxt_x   = {2'b00, nxt_ptr};
    mag_x   = rd_step[AW-1] ? {2'b00, (~rd_step + 1'b1)} : {2'b00, rd_step};
    ok_win  = (rd_size != '0) && (ptr_x >= start_x) && (ptr_x < end_x) &&
              (mag_x <= size_x) && (end_x <= SPAN);
    nxt_in  = (nxt_x >= start_x) && (nxt_x < end_x);
  end

  AST_VLD_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> addr_vld); // R2
  AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !addr_vld); // R11
  AST_IDLE_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(addr)); // R11
  AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !brev_en) |=> (addr == $past(rd_ptr))); // R2
  AST_BREV_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && brev_en && (brev_bits == '0)) |=> (addr == $past(rd_ptr))); // R7
  AST_WRAP_POS_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && ok_win && !rd_step[AW-1]) |-> nxt_in); // R4
  AST_WRAP_NEG_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && ok_win && rd_step[AW-1]) |-> nxt_in); // R5

endmodule

bind circ_dag dag_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_en    (acc_en),
  .brev_en   (brev_en),
  .brev_bits (brev_bits),
  .addr_vld  (addr_vld),
  .addr      (addr),
  .rd_ptr    (rd_ptr),
  .rd_step   (rd_step),
  .rd_size   (rd_size),
  .rd_start  (rd_start),
  .nxt_ptr   (nxt_ptr)
);

// File: tb/tb_circ_dag.sv
module tb_circ_dag;

  localparam int AW   = 32;
  localparam int NBUF = 8;
  localparam int BUFW = 3;
  localparam int BW   = 6;
  localparam int NVEC = 7;

  // Columns: start, size, step, initial pointer, four expected addresses.
  localparam logic [31:0] TV [0:NVEC-1][0:7] = '{
    '{32'd100, 32'd7, 32'd3, 32'd100, 32'd100, 32'd103, 32'd106, 32'd102},                 // R4 R6
    '{32'd100, 32'd7, 32'hFFFF_FFFD, 32'd101, 32'd101, 32'd105, 32'd102, 32'd106},         // R5 R6
    '{32'd0, 32'd0, 32'd5, 32'd10, 32'd10, 32'd15, 32'd20, 32'd25},                        // R3
    '{32'd0, 32'd0, 32'hFFFF_FFFC, 32'd2, 32'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFA, 32'hFFFF_FFF6}, // R3
    '{32'h20, 32'd16, 32'd16, 32'h25, 32'h25, 32'h25, 32'h25, 32'h25},                     // R4
    '{32'hFFFF_FFF0, 32'h10, 32'd8, 32'hFFFF_FFF8, 32'hFFFF_FFF8, 32'hFFFF_FFF0, 32'hFFFF_FFF8, 32'hFFFF_FFF0}, // R4 R6
    '{32'd7, 32'd5, 32'hFFFF_FFFB, 32'd9, 32'd9, 32'd9, 32'd9, 32'd9}                      // R5
  };

  logic            clk;
  logic            rst_n;
  logic            bank_sel;
  logic            acc_en;
  logic [BUFW-1:0] acc_buf;
  logic            brev_en;
  logic [BW-1:0]   brev_bits;
  logic            wr_en;
  logic            wr_bank;
  logic [BUFW-1:0] wr_buf;
  logic [1:0]      wr_field;
  logic [AW-1:0]   wr_data;
  logic            addr_vld;
  logic [AW-1:0]   addr;

  int checks = 0;
  int errors = 0;

  circ_dag #(.AW(AW), .NBUF(NBUF)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .acc_en    (acc_en),
    .acc_buf   (acc_buf),
    .brev_en   (brev_en),
    .brev_bits (brev_bits),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_buf    (wr_buf),
    .wr_field  (wr_field),
    .wr_data   (wr_data),
    .addr_vld  (addr_vld),
    .addr      (addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic cyc(input logic we, input logic wb, input int wbuf, input int wf,
                     input logic [31:0] wd, input logic ae, input logic ab,
                     input int abuf, input logic be, input int bits);
    wr_en     = we;
    wr_bank   = wb;
    wr_buf    = BUFW'(wbuf);
    wr_field  = 2'(wf);
    wr_data   = wd;
    acc_en    = ae;
    bank_sel  = ab;
    acc_buf   = BUFW'(abuf);
    brev_en   = be;
    brev_bits = BW'(bits);
    @(posedge clk);
    @(negedge clk);
    wr_en  = 1'b0;
    acc_en = 1'b0;
  endtask

  task automatic wr(input logic b, input int bf, input int f, input logic [31:0] d);
    cyc(1'b1, b, bf, f, d, 1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  // Field codes: 0 pointer, 1 step, 2 size, 3 start (R10).
  task automatic setbuf(input logic b, input int bf, input logic [31:0] st,
                        input logic [31:0] sz, input logic [31:0] sp, input logic [31:0] p);
    wr(b, bf, 3, st);
    wr(b, bf, 2, sz);
    wr(b, bf, 1, sp);
    wr(b, bf, 0, p);
  endtask

  task automatic acc_chk(input string req, input logic b, input int bf, input logic be,
                         input int bits, input logic [31:0] exp);
    cyc(1'b0, 1'b0, 0, 0, 32'd0, 1'b1, b, bf, be, bits);
    chk({req, " vld"}, {31'd0, addr_vld}, 32'd1);
    chk(req, addr, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_bank = 1'b0; wr_buf = '0; wr_field = '0; wr_data = '0;
    acc_en = 1'b0; bank_sel = 1'b0; acc_buf = '0; brev_en = 1'b0; brev_bits = '0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", {31'd0, addr_vld}, 32'd0);
    chk("R1 addr in reset", addr, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after reset", {31'd0, addr_vld}, 32'd0);
    chk("R1 addr after reset", addr, 32'd0);
    acc_chk("R1 R2 unwritten descriptor", 1'b1, 7, 1'b0, 0, 32'd0);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      setbuf(1'(v % 2), v, TV[v][0], TV[v][1], TV[v][2], TV[v][3]);
      for (int k = 0; k < 4; k++) begin
        acc_chk($sformatf("R2 R3 R4 R5 R6 vector %0d step %0d", v, k),
                1'(v % 2), v, 1'b0, 0, TV[v][4+k]);
      end
    end

    // R11: a cycle with only a write leaves the address alone
    wr(1'b0, 6, 2, 32'd0);
    chk("R11 vld low when idle", {31'd0, addr_vld}, 32'd0);
    chk("R11 addr held when idle", addr, 32'd9);

    // R10: field codes and targeting of bank and descriptor
    setbuf(1'b1, 0, 32'd0, 32'd0, 32'd0, 32'h777);
    setbuf(1'b0, 0, 32'd0, 32'd0, 32'd0, 32'h111);
    acc_chk("R10 pointer write hits only its bank", 1'b0, 0, 1'b0, 0, 32'h111);
    wr(1'b0, 0, 1, 32'd2);
    acc_chk("R10 step field code 1", 1'b0, 0, 1'b0, 0, 32'h111);
    acc_chk("R10 step applied", 1'b0, 0, 1'b0, 0, 32'h113);

    // R8: bank select per access, other bank retained
    acc_chk("R8 secondary bank", 1'b1, 0, 1'b0, 0, 32'h777);
    acc_chk("R8 primary bank retained", 1'b0, 0, 1'b0, 0, 32'h115);
    acc_chk("R8 secondary unchanged step 0", 1'b1, 0, 1'b0, 0, 32'h777);

    // R9: write-first when write and access meet
    cyc(1'b1, 1'b0, 0, 0, 32'd500, 1'b1, 1'b0, 0, 1'b0, 0);
    chk("R9 same-cycle pointer write", addr, 32'd500);
    acc_chk("R9 written pointer advanced", 1'b0, 0, 1'b0, 0, 32'd502);
    cyc(1'b1, 1'b0, 0, 1, 32'd10, 1'b1, 1'b0, 0, 1'b0, 0);
    chk("R9 same-cycle step write addr", addr, 32'd504);
    acc_chk("R9 same-cycle step used", 1'b0, 0, 1'b0, 0, 32'd514);

    // R7: mirrored low bits, pointer advances linearly
    setbuf(1'b0, 2, 32'd0, 32'd0, 32'd1, 32'd1);
    acc_chk("R7 3 bits of 1", 1'b0, 2, 1'b1, 3, 32'd4);
    acc_chk("R7 3 bits of 2", 1'b0, 2, 1'b1, 3, 32'd2);
    acc_chk("R7 3 bits of 3", 1'b0, 2, 1'b1, 3, 32'd6);
    wr(1'b0, 2, 0, 32'h1F1);
    acc_chk("R7 upper bits kept", 1'b0, 2, 1'b1, 4, 32'h1F8);
    acc_chk("R7 zero bits identity", 1'b0, 2, 1'b1, 0, 32'h1F2);
    setbuf(1'b1, 3, 32'd8, 32'd4, 32'd3, 32'd10);
    acc_chk("R7 mirrored with window", 1'b1, 3, 1'b1, 2, 32'd9);
    acc_chk("R7 pointer wrapped under mirror", 1'b1, 3, 1'b1, 2, 32'd10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule